// File: doc/BRIEF.md
# Dual-Width Mailbox FIFO Pair with Half-Word Steering

This block holds two 8-entry, 32-bit word queues between a host port and a local port: one carries words from host to local, the other from local to host. The host side always moves whole words, one per cycle, over valid/ready streams. The local side uses active-low read and write strobes. Each strobe acts as an enable that is sampled on the rising clock edge, and the local data is registered on that edge. Both ports share one clock.

The local port runs either 32 bits wide or 16 bits wide. In the narrow mode, a phase bit in each direction steers successive accesses to alternate halves of a word. The queue moves only on the access to the chosen "advance" half. A separate configuration input for each direction picks that half, so the application may touch the halves in either order. A local strobe that meets a full or empty queue is discarded inside the block, and a one-cycle pulse reports the discard. This keeps the phase bit in step with the queue.

Each direction has three status flags, and the host can clear each direction on its own.

Top module: `mbox_fifo_pair`

## Requirements
- R1: With `loc_mode16`=0, each accepted local write pushes all 32 bits of `loc_wdata`. Each accepted local read pops the head of the host-to-local queue, and that word appears on `loc_rdata` after the same edge. Both queues keep first-in first-out order.
- R2: With `loc_mode16`=1, local writes take `loc_wdata[15:0]` and alternate between two phases. When `loc_wr_adv_hi`=1, the first write supplies word bits 15:0 and the second supplies bits 31:16 and pushes the word. When `loc_wr_adv_hi`=0, the first supplies bits 31:16 and the second supplies bits 15:0 and pushes.
- R3: With `loc_mode16`=1, local reads alternate phases over the head word and place the selected half on `loc_rdata[15:0]`, with bits 31:16 at zero. When `loc_rd_adv_hi`=1, the first read returns bits 15:0 and the second returns bits 31:16 and pops. When `loc_rd_adv_hi`=0, the order is bits 31:16 and then bits 15:0, and the pop happens on the second read.
- R4: A local write while `l2h_full`=1 is discarded. Queue contents and the write phase are unchanged, and `loc_wr_ovf` is high for exactly the following cycle.
- R5: A local read while `h2l_empty`=1 is discarded. `loc_rdata` and the read phase are unchanged, and `loc_rd_unf` is high for exactly the following cycle.
- R6: `h2l_in_ready` equals the inverse of `h2l_full`, and a word moves when `h2l_in_valid` and `h2l_in_ready` are both high. `l2h_out_valid` is high when the local-to-host queue is not empty, and `l2h_out_data` is its head. A pop happens on valid and ready, and while valid is high with ready low the data holds steady.
- R7: `h2l_empty` is high when the host-to-local queue holds 0 words. `h2l_free4` is high when it holds 4 or fewer. `h2l_full` is high when it holds 8. The flags follow the edge that changes the occupancy.
- R8: `l2h_empty` is high when the local-to-host queue holds 0 words. `l2h_used4` is high when it holds 4 or more. `l2h_full` is high when it holds 8. The flags follow the edge that changes the occupancy.
- R9: A high `h2l_clr` empties the host-to-local queue and returns its read phase to the first half, and a high `l2h_clr` does the same for the local-to-host queue and its write phase. A clear wins over a push in the same cycle, and neither clear touches the other direction.
- R10: After reset, both queues are empty, both phases are at the first half, and `loc_rdata`, `loc_wr_ovf` and `loc_rd_unf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_mode16 | input | 1 | 1 selects the 16-bit local port, 0 selects 32-bit |
| loc_wr_adv_hi | input | 1 | 1 = a local write pushes on the upper half |
| loc_rd_adv_hi | input | 1 | 1 = a local read pops on the upper half |
| h2l_in_valid | input | 1 | Host word offered |
| h2l_in_ready | output | 1 | Host-to-local queue can accept |
| h2l_in_data | input | 32 | Host word |
| l2h_out_valid | output | 1 | Local-to-host word available |
| l2h_out_ready | input | 1 | Host takes the word |
| l2h_out_data | output | 32 | Head of the local-to-host queue |
| h2l_clr | input | 1 | Clear host-to-local queue and read phase |
| l2h_clr | input | 1 | Clear local-to-host queue and write phase |
| loc_rd_n | input | 1 | Local read enable, active low |
| loc_rdata | output | 32 | Registered local read data |
| loc_wr_n | input | 1 | Local write enable, active low |
| loc_wdata | input | 32 | Local write data (bits 15:0 in 16-bit mode) |
| h2l_empty | output | 1 | Host-to-local queue empty |
| h2l_free4 | output | 1 | Host-to-local queue has 4 or more free places |
| h2l_full | output | 1 | Host-to-local queue full |
| l2h_empty | output | 1 | Local-to-host queue empty |
| l2h_used4 | output | 1 | Local-to-host queue holds 4 or more words |
| l2h_full | output | 1 | Local-to-host queue full |
| loc_wr_ovf | output | 1 | Pulse: a local write was discarded |
| loc_rd_unf | output | 1 | Pulse: a local read was discarded |

## Verification
The bench builds the block with the defaults, a depth of 8 and a flag threshold of 4. At these values a queue can be driven from empty, through the threshold and up to full within a dozen cycles. That makes discarded strobes on both sides, and threshold crossings in both directions, frequent under random traffic. The stimulus is split into segments, one for each combination of port width and advance half, and a clear precedes each segment. As a result, every steering order is checked starting from a known phase, and the phase is also checked after mid-word clears.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/mbox_fifo_core.sv
module mbox_fifo_core
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned THRESH      = 4,
  parameter bit          THR_ON_FREE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  push,
  input  word_t push_data,
  input  logic  pop,
  output word_t head,
  output logic  empty,
  output logic  full,
  output logic  thr
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] THR_CNT  = CNT_W'(THRESH);

  word_t            mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

  generate
    if (THR_ON_FREE) begin : g_free
      assign thr = (FULL_CNT - count) >= THR_CNT;
    end else begin : g_used
      assign thr = count >= THR_CNT;
    end
  endgenerate

  // R4: pushes arriving from the strobe gating never meet a full queue
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !clr));
  // R5: pops never meet an empty queue
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
  // R9: a clear leaves the queue empty
  assert_clr_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  // R7: a lone push leaves the queue non-empty
  assert_push_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |=> !empty);
endmodule

// File: rtl/mbox_wr_packer.sv
module mbox_wr_packer
  import mbox_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  mode16,
  input  logic  adv_hi,
  input  logic  stb,
  input  word_t data,
  input  logic  full,
  output logic  push,
  output word_t push_data,
  output logic  ovf
);
  logic  phase;
  half_t hold;
  logic  accept;

  assign accept = stb && !full;

  always_comb begin
    push      = 1'b0;
    push_data = data;
    if (!mode16) begin
      push = accept;
    end else if (phase) begin
      push      = accept;
      push_data = adv_hi ? {data[HALF_W-1:0], hold} : {hold, data[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      hold  <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= stb && full;
      if (mode16 && accept && !phase) hold <= data[HALF_W-1:0];
      if (clr)                        phase <= 1'b0;
      else if (mode16 && accept)      phase <= !phase;
    end
  end

  // R4: a discarded write leaves the half-word phase where it was
  assert_wr_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && full && !clr) |=> $stable(phase));
  // R2: in 32-bit mode the phase never leaves the first half
  assert_wide_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode16 && !phase) |=> !phase);
endmodule

// File: rtl/mbox_rd_splitter.sv
module mbox_rd_splitter
  import mbox_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  mode16,
  input  logic  adv_hi,
  input  logic  stb,
  input  word_t head,
  input  logic  empty,
  output logic  pop,
  output word_t rdata,
  output logic  unf
);
  logic phase;
  logic accept;
  logic sel_hi;

  assign accept = stb && !empty;
  assign pop    = accept && (!mode16 || phase);
  assign sel_hi = phase ? adv_hi : !adv_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      rdata <= '0;
      unf   <= 1'b0;
    end else begin
      unf <= stb && empty;
      if (accept) begin
        if (mode16) rdata <= {{HALF_W{1'b0}}, sel_hi ? head[WORD_W-1:HALF_W] : head[HALF_W-1:0]};
        else        rdata <= head;
      end
      if (clr)                   phase <= 1'b0;
      else if (mode16 && accept) phase <= !phase;
    end
  end

  // R5: a discarded read leaves the data and the phase untouched
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && empty && !clr) |=> ($stable(rdata) && $stable(phase)));
  // R3: narrow reads keep the upper output half at zero
  assert_narrow_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && accept) |=> (rdata[WORD_W-1:HALF_W] == '0));
endmodule

// File: rtl/mbox_fifo_pair.sv
module mbox_fifo_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned THRESH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loc_mode16,
  input  logic        loc_wr_adv_hi,
  input  logic        loc_rd_adv_hi,
  input  logic        h2l_in_valid,
  output logic        h2l_in_ready,
  input  logic [31:0] h2l_in_data,
  output logic        l2h_out_valid,
  input  logic        l2h_out_ready,
  output logic [31:0] l2h_out_data,
  input  logic        h2l_clr,
  input  logic        l2h_clr,
  input  logic        loc_rd_n,
  output logic [31:0] loc_rdata,
  input  logic        loc_wr_n,
  input  logic [31:0] loc_wdata,
  output logic        h2l_empty,
  output logic        h2l_free4,
  output logic        h2l_full,
  output logic        l2h_empty,
  output logic        l2h_used4,
  output logic        l2h_full,
  output logic        loc_wr_ovf,
  output logic        loc_rd_unf
);
  logic  h2l_push, h2l_pop, l2h_push, l2h_pop;
  word_t h2l_head, l2h_pdata;

  assign h2l_in_ready  = !h2l_full;
  assign h2l_push      = h2l_in_valid && h2l_in_ready;
  assign l2h_out_valid = !l2h_empty;
  assign l2h_pop       = l2h_out_valid && l2h_out_ready;

  mbox_fifo_core #(.DEPTH(DEPTH), .THRESH(THRESH), .THR_ON_FREE(1'b1)) u_h2l (
    .clk(clk), .rst_n(rst_n), .clr(h2l_clr),
    .push(h2l_push), .push_data(h2l_in_data), .pop(h2l_pop),
    .head(h2l_head), .empty(h2l_empty), .full(h2l_full), .thr(h2l_free4));

  mbox_rd_splitter u_rd (
    .clk(clk), .rst_n(rst_n), .clr(h2l_clr),
    .mode16(loc_mode16), .adv_hi(loc_rd_adv_hi), .stb(!loc_rd_n),
    .head(h2l_head), .empty(h2l_empty),
    .pop(h2l_pop), .rdata(loc_rdata), .unf(loc_rd_unf));

  mbox_wr_packer u_wr (
    .clk(clk), .rst_n(rst_n), .clr(l2h_clr),
    .mode16(loc_mode16), .adv_hi(loc_wr_adv_hi), .stb(!loc_wr_n),
    .data(loc_wdata), .full(l2h_full),
    .push(l2h_push), .push_data(l2h_pdata), .ovf(loc_wr_ovf));

  mbox_fifo_core #(.DEPTH(DEPTH), .THRESH(THRESH), .THR_ON_FREE(1'b0)) u_l2h (
    .clk(clk), .rst_n(rst_n), .clr(l2h_clr),
    .push(l2h_push), .push_data(l2h_pdata), .pop(l2h_pop),
    .head(l2h_out_data), .empty(l2h_empty), .full(l2h_full), .thr(l2h_used4));

  // R6: an offered but untaken word holds steady
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l2h_out_valid && !l2h_out_ready && !l2h_clr) |=> (l2h_out_valid && $stable(l2h_out_data)));
  // R9: clearing one direction does not empty the other
  assert_clr_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h2l_clr && !l2h_clr && l2h_used4 && !l2h_out_ready) |=> !l2h_empty);
endmodule

// File: tb/mbox_fifo_pair_tb.sv
module mbox_fifo_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_mode16 = 1'b0, loc_wr_adv_hi = 1'b1, loc_rd_adv_hi = 1'b1;
  logic        h2l_in_valid = 1'b0, l2h_out_ready = 1'b0;
  logic [31:0] h2l_in_data = '0, loc_wdata = '0;
  logic        h2l_clr = 1'b0, l2h_clr = 1'b0, loc_rd_n = 1'b1, loc_wr_n = 1'b1;
  logic        h2l_in_ready, l2h_out_valid;
  logic [31:0] l2h_out_data, loc_rdata;
  logic        h2l_empty, h2l_free4, h2l_full, l2h_empty, l2h_used4, l2h_full;
  logic        loc_wr_ovf, loc_rd_unf;

  always #2.5 clk = ~clk;

  mbox_fifo_pair u_dut (.*);

  int unsigned checks = 0, fails = 0;
  bit          done = 1'b0;
  logic [31:0] h2l_q[$], l2h_q[$];
  bit          rph = 1'b0, wph = 1'b0;
  logic [15:0] whold = '0;
  logic [31:0] e_rdata = '0;
  bit          e_ovf = 1'b0, e_unf = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_free4(int n); return (8 - n) >= 4; endfunction
  function automatic bit exp_used4(int n); return n >= 4; endfunction

  task automatic cyc(input bit hv, input logic [31:0] hd, input bit ordy,
                     input bit lrd, input bit lwr, input logic [31:0] lwd,
                     input bit hc, input bit lc);
    bit hpush, hpop, lpush, lpop;
    logic [31:0] lword;
    h2l_in_valid = hv; h2l_in_data = hd; l2h_out_ready = ordy;
    loc_rd_n = !lrd; loc_wr_n = !lwr; loc_wdata = lwd;
    h2l_clr = hc; l2h_clr = lc;
    #1;
    chk(h2l_in_ready == (h2l_q.size() < 8), "R6", "h2l_in_ready", 32'(h2l_in_ready), 32'(h2l_q.size() < 8));
    chk(l2h_out_valid == (l2h_q.size() != 0), "R6", "l2h_out_valid", 32'(l2h_out_valid), 32'(l2h_q.size() != 0));
    if (l2h_q.size() != 0) chk(l2h_out_data == l2h_q[0], "R6", "l2h_out_data", l2h_out_data, l2h_q[0]);
    e_ovf = lwr && (l2h_q.size() == 8);
    e_unf = lrd && (h2l_q.size() == 0);
    hpush = hv && (h2l_q.size() < 8);
    hpop = 1'b0; lpush = 1'b0; lword = lwd;
    if (lrd && h2l_q.size() > 0) begin
      if (!loc_mode16) begin
        e_rdata = h2l_q[0]; hpop = 1'b1;
      end else begin
        bit hi;
        hi = rph ? loc_rd_adv_hi : !loc_rd_adv_hi;
        e_rdata = {16'h0, hi ? h2l_q[0][31:16] : h2l_q[0][15:0]};
        if (rph) hpop = 1'b1;
        rph = !rph;
      end
    end
    lpop = ordy && (l2h_q.size() > 0);
    if (lwr && l2h_q.size() < 8) begin
      if (!loc_mode16) lpush = 1'b1;
      else if (!wph) begin whold = lwd[15:0]; wph = 1'b1; end
      else begin
        lword = loc_wr_adv_hi ? {lwd[15:0], whold} : {whold, lwd[15:0]};
        lpush = 1'b1; wph = 1'b0;
      end
    end
    if (hpop) void'(h2l_q.pop_front());
    if (hpush) h2l_q.push_back(hd);
    if (lpop) void'(l2h_q.pop_front());
    if (lpush) l2h_q.push_back(lword);
    if (hc) begin h2l_q.delete(); rph = 1'b0; end
    if (lc) begin l2h_q.delete(); wph = 1'b0; end
    @(posedge clk); @(negedge clk);
    h2l_in_valid = 1'b0; l2h_out_ready = 1'b0; loc_rd_n = 1'b1; loc_wr_n = 1'b1;
    h2l_clr = 1'b0; l2h_clr = 1'b0;
    chk(h2l_empty == (h2l_q.size() == 0), "R7", "h2l_empty", 32'(h2l_empty), 32'(h2l_q.size() == 0));
    chk(h2l_free4 == exp_free4(h2l_q.size()), "R7", "h2l_free4", 32'(h2l_free4), 32'(exp_free4(h2l_q.size())));
    chk(h2l_full == (h2l_q.size() == 8), "R7", "h2l_full", 32'(h2l_full), 32'(h2l_q.size() == 8));
    chk(l2h_empty == (l2h_q.size() == 0), "R8", "l2h_empty", 32'(l2h_empty), 32'(l2h_q.size() == 0));
    chk(l2h_used4 == exp_used4(l2h_q.size()), "R8", "l2h_used4", 32'(l2h_used4), 32'(exp_used4(l2h_q.size())));
    chk(l2h_full == (l2h_q.size() == 8), "R8", "l2h_full", 32'(l2h_full), 32'(l2h_q.size() == 8));
    chk(loc_rdata == e_rdata, loc_mode16 ? "R3" : "R1", "loc_rdata", loc_rdata, e_rdata);
    chk(loc_wr_ovf == e_ovf, "R4", "loc_wr_ovf", 32'(loc_wr_ovf), 32'(e_ovf));
    chk(loc_rd_unf == e_unf, "R5", "loc_rd_unf", 32'(loc_rd_unf), 32'(e_unf));
  endtask

  task automatic clear_both();
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(h2l_empty && h2l_free4 && !h2l_full, "R10", "h2l flags", {h2l_empty, h2l_free4, h2l_full}, 3'b110);
    chk(l2h_empty && !l2h_used4 && !l2h_full, "R10", "l2h flags", {l2h_empty, l2h_used4, l2h_full}, 3'b100);
    chk(loc_rdata == 0 && !loc_wr_ovf && !loc_rd_unf, "R10", "local outputs", loc_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R4/R8: 32-bit writes up to full, then one discarded
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 1, 32'hA000_0000 + i, 0, 0);
    // R6: hold, then drain
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0);
    // R6/R7: host fills, one extra refused; R1/R5: read all, one discarded
    for (int i = 0; i < 9; i++) cyc(1, 32'hB000_0000 + i, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);

    // R2/R3: narrow mode, both advance orders
    for (int a = 0; a < 2; a++) begin
      loc_mode16 = 1'b1; loc_wr_adv_hi = a[0]; loc_rd_adv_hi = !a[0];
      clear_both();
      for (int i = 0; i < 4; i++) cyc(1, 32'h1234_5678 + 32'(i) * 32'h0101_0101, 0, 0, 1, 32'h0000_C000 + i, 0, 0);
      for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
      // R4: fill to full, then a dropped first half must not shift the phase
      for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1, 32'h0000_D000 + i, 0, 0);
      cyc(0, 0, 0, 0, 1, 32'h0000_EEEE, 0, 0);
      cyc(0, 0, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 32'h0000_1111, 0, 0);
      cyc(0, 0, 0, 0, 1, 32'h0000_2222, 0, 0);
      for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0);
    end

    // R9: clear one direction mid-word, the other untouched
    loc_wr_adv_hi = 1'b1; loc_rd_adv_hi = 1'b1;
    clear_both();
    for (int i = 0; i < 5; i++) cyc(1, 32'hC0DE_0000 + i, 0, 0, 1, 32'h0000_F000 + i, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) cyc(1, 32'h5EED_0000 + i, 0, 1, 1, 32'h0000_9000 + i, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 0, 0, 0, 0);

    // random segments over every width/order combination
    for (int s = 0; s < 8; s++) begin
      int pw, pr, ph, po;
      loc_mode16 = s[2]; loc_wr_adv_hi = s[1]; loc_rd_adv_hi = s[0];
      pw = 30 + 10 * (s % 4); pr = 70 - 10 * (s % 4);
      ph = 60 - 10 * (s % 3); po = 40 + 10 * (s % 3);
      clear_both();
      for (int i = 0; i < 1200; i++)
        cyc($urandom_range(0, 99) < ph, $urandom, $urandom_range(0, 99) < po,
            $urandom_range(0, 99) < pr, $urandom_range(0, 99) < pw, $urandom,
            $urandom_range(0, 199) == 0, $urandom_range(0, 199) == 0);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
      finish_run();
    end
  end
endmodule